// File: doc/BRIEF.md
# Edge-interrupt GPIO controller

This block controls one group of 32 general-purpose pins from a plain register bus. Software chooses the direction of each pin and changes the output latch by writing masks to separate set and clear addresses, so a single pin can be changed without a read-modify-write. The pad levels pass through a synchroniser into an input register. That register shows the real pin level even for pins that the block itself drives.

Each pin has a rising-edge enable and a falling-edge enable. Both masks are also changed through set and clear addresses. An enabled edge latches a bit in a status register, which software clears by writing ones. The status bits are combined into two bank interrupt lines, one for pins 0–15 and one for pins 16–31. Each line is gated by its own bit in a bank-enable register.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset these values hold: direction reads all ones, and no pin is driven (pad_oe = 0). Output latch, both edge masks, status, bank enable and both bank_irq lines are all zero.
- R2: A write to 0x18 sets to 1 every output latch bit whose write-data bit is 1. A write to 0x1C clears to 0 every latch bit whose write-data bit is 1. Bits written 0 keep their value. The latch reads back at 0x14 and drives pad_out.
- R3: The direction register at 0x10 is read-write. A bit value of 1 makes the pin an input (pad_oe bit 0). A bit value of 0 drives the latch onto the pin (pad_oe bit 1).
- R4: The register at 0x20 returns the pad level through a two-flop synchroniser, for input and output pins alike. A read issued right after an output write still returns the old level.
- R5: The rising mask is set by writing ones to 0x24 and cleared by writing ones to 0x28. The falling mask is set by writing ones to 0x2C and cleared by writing ones to 0x30. A read of 0x24 or 0x2C returns the current mask. A read of 0x18, 0x1C, 0x28 or 0x30 returns 0.
- R6: A pin sets its status bit (register 0x34) when its synchronised level rises while its rising-mask bit is set, or falls while its falling-mask bit is set. An edge that is not enabled has no effect.
- R7: Writing to 0x34 clears every status bit written 1. Bits written 0 keep their value.
- R8: When a status clear and a new enabled edge hit the same bit in the same cycle, the bit stays set.
- R9: Bank enable sits at 0x08 in bits [1:0]. bank_irq[0] is high exactly when enable bit 0 is set and any status bit 15..0 is set. bank_irq[1] does the same for enable bit 1 and status bits 31..16.
- R10: Read data appears on bus_rdata in the cycle after bus_rd is sampled. It is zero when no read was sampled.

Port table notes: the register group starts at byte address 0x10, and the low two address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Output latch to pads |
| pad_oe | output | 32 | Per-pin output enable |
| bank_irq | output | 2 | Bank interrupt requests |

## Verification
Every pin in turn receives a rising pulse and then a falling pulse. The edge masks use four patterns: rise only, fall only, both, and neither. This separates the polarity handling of each pin and catches crossed or missing bits. During the sweep the bank-enable value rotates through off, low-bank-only and both-banks, which shows that gating and the 16-pin split are independent. The pads are looped back so that driven pins show up in the input register, and the one-cycle-stale read then checks the synchroniser depth. A clear aimed at the cycle of a new edge checks the priority rule.

// File: rtl/gpio_edge_ctl.sv
`timescale 1ns/1ps
module gpio_edge_ctl #(
  parameter int PINS        = 32,
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int GROUP_BASE  = 'h10,
  parameter int BANKEN_ADDR = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS/BANK_W-1:0] bank_irq
);
  localparam int BANKS = PINS / BANK_W;
  localparam logic [ADDR_W-1:0] A_BANKEN = ADDR_W'(BANKEN_ADDR);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(GROUP_BASE + 'h00);
  localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(GROUP_BASE + 'h04);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(GROUP_BASE + 'h08);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(GROUP_BASE + 'h0C);
  localparam logic [ADDR_W-1:0] A_IN     = ADDR_W'(GROUP_BASE + 'h10);
  localparam logic [ADDR_W-1:0] A_RSET   = ADDR_W'(GROUP_BASE + 'h14);
  localparam logic [ADDR_W-1:0] A_RCLR   = ADDR_W'(GROUP_BASE + 'h18);
  localparam logic [ADDR_W-1:0] A_FSET   = ADDR_W'(GROUP_BASE + 'h1C);
  localparam logic [ADDR_W-1:0] A_FCLR   = ADDR_W'(GROUP_BASE + 'h20);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(GROUP_BASE + 'h24);

  logic [PINS-1:0]  dir_q, out_q, rise_q, fall_q, stat_q, prev_q, rdata_q;
  logic [PINS-1:0]  sync_q [SYNC_STAGES];
  logic [BANKS-1:0] bank_en_q;
  logic [PINS-1:0]  in_now, ev_rise, ev_fall, rd_mux;
  logic [ADDR_W-3:0] word;

  assign word = bus_addr[ADDR_W-1:2];

  logic w_banken, w_dir, w_set, w_clr, w_rset, w_rclr, w_fset, w_fclr, w_stat;
  assign w_banken = bus_wr && word == A_BANKEN[ADDR_W-1:2];
  assign w_dir    = bus_wr && word == A_DIR[ADDR_W-1:2];
  assign w_set    = bus_wr && word == A_SET[ADDR_W-1:2];
  assign w_clr    = bus_wr && word == A_CLR[ADDR_W-1:2];
  assign w_rset   = bus_wr && word == A_RSET[ADDR_W-1:2];
  assign w_rclr   = bus_wr && word == A_RCLR[ADDR_W-1:2];
  assign w_fset   = bus_wr && word == A_FSET[ADDR_W-1:2];
  assign w_fclr   = bus_wr && word == A_FCLR[ADDR_W-1:2];
  assign w_stat   = bus_wr && word == A_STAT[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      bank_en_q <= '0;
    end else begin
      if (w_dir)    dir_q     <= bus_wdata;
      if (w_set)    out_q     <= out_q | bus_wdata;
      if (w_clr)    out_q     <= out_q & ~bus_wdata;
      if (w_rset)   rise_q    <= rise_q | bus_wdata;
      if (w_rclr)   rise_q    <= rise_q & ~bus_wdata;
      if (w_fset)   fall_q    <= fall_q | bus_wdata;
      if (w_fclr)   fall_q    <= fall_q & ~bus_wdata;
      if (w_banken) bank_en_q <= bus_wdata[BANKS-1:0];
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign in_now  = sync_q[SYNC_STAGES-1];
  assign ev_rise = in_now & ~prev_q & rise_q;
  assign ev_fall = ~in_now & prev_q & fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~(w_stat ? bus_wdata : '0)) | ev_rise | ev_fall;
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign bank_irq[b] = bank_en_q[b] & |stat_q[b*BANK_W +: BANK_W];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    unique case (word)
      A_BANKEN[ADDR_W-1:2]: rd_mux = PINS'(bank_en_q);
      A_DIR[ADDR_W-1:2]:    rd_mux = dir_q;
      A_OUT[ADDR_W-1:2]:    rd_mux = out_q;
      A_IN[ADDR_W-1:2]:     rd_mux = in_now;
      A_RSET[ADDR_W-1:2]:   rd_mux = rise_q;
      A_FSET[ADDR_W-1:2]:   rd_mux = fall_q;
      A_STAT[ADDR_W-1:2]:   rd_mux = stat_q;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  assert_dir_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_dir |=> pad_oe == ~$past(bus_wdata));
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> (pad_out & $past(bus_wdata)) == $past(bus_wdata));
  assert_clr_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> (pad_out & $past(bus_wdata)) == '0);
  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise | ev_fall) != '0 |=> (stat_q & $past(ev_rise | ev_fall)) == $past(ev_rise | ev_fall));
  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_stat |=> (stat_q & $past(bus_wdata) & ~$past(ev_rise | ev_fall)) == '0);
  assert_no_stray_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
endmodule

// File: tb/gpio_edge_ctl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in, pad_out, pad_oe, ext = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bank_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_edge_ctl u_gpio_edge_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .bank_irq(bank_irq));

  localparam logic [7:0] BE = 8'h08, DIR = 8'h10, OUTR = 8'h14, SETD = 8'h18,
    CLRD = 8'h1C, INR = 8'h20, RSET = 8'h24, RCLR = 8'h28, FSET = 8'h2C,
    FCLR = 8'h30, STAT = 8'h34;
  localparam logic [31:0] RMASK = 32'h3333_3333, FMASK = 32'h5555_5555;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(posedge clk); #1 d = bus_rdata; bus_rd = 0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [1:0] be, stat_exp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 bank_irq", {30'h0, bank_irq}, 32'h0);
    rchk("R1 dir", DIR, 32'hFFFF_FFFF);
    rchk("R1 out", OUTR, 32'h0);
    rchk("R1 rise mask", RSET, 32'h0);
    rchk("R1 fall mask", FSET, 32'h0);
    rchk("R1 status", STAT, 32'h0);
    rchk("R1 bank enable", BE, 32'h0);
    #1 chk("R10 idle rdata", bus_rdata, 32'h0);

    wr(SETD, 32'h0000_00F5);
    chk("R2 set", pad_out, 32'h0000_00F5);
    wr(SETD, 32'h8000_0000);
    wr(CLRD, 32'h0000_0014);
    rchk("R2 clear", OUTR, 32'h8000_00E1);
    wr(CLRD, 32'h0);
    rchk("R2 zero clear", OUTR, 32'h8000_00E1);
    rchk("R5 set addr reads 0", SETD, 32'h0);
    rchk("R5 clr addr reads 0", CLRD, 32'h0);

    wr(DIR, 32'h7FFF_FF00);
    chk("R3 oe", pad_oe, 32'h8000_00FF);
    rchk("R3 dir read", DIR, 32'h7FFF_FF00);
    settle();
    rchk("R4 driven pins visible", INR, 32'h8000_00E1);
    wr(SETD, 32'h0000_0002);
    rchk("R4 stale read", INR, 32'h8000_00E1);
    settle();
    rchk("R4 updated read", INR, 32'h8000_00E3);
    ext = 32'h0A00_0000;
    settle();
    rchk("R4 input pins", INR, 32'h8A00_00E3);
    wr(CLRD, 32'hFFFF_FFFF);
    wr(DIR, 32'hFFFF_FFFF);
    ext = '0;
    settle();
    rchk("R4 back to zero", INR, 32'h0);

    wr(RSET, RMASK);
    wr(FSET, FMASK);
    rchk("R5 rise read", RSET, RMASK);
    rchk("R5 fall read", FSET, FMASK);
    rchk("R5 rclr reads 0", RCLR, 32'h0);
    rchk("R5 fclr reads 0", FCLR, 32'h0);
    rchk("R6 no status yet", STAT, 32'h0);

    for (int i = 0; i < 32; i++) begin
      be = (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b01 : 2'b11);
      wr(BE, {30'h0, be});
      @(negedge clk); ext[i] = 1'b1;
      settle();
      rchk($sformatf("R6 rise pin %0d", i), STAT, RMASK[i] ? (32'h1 << i) : 32'h0);
      stat_exp = RMASK[i] ? ((i < 16) ? 2'b01 : 2'b10) : 2'b00;
      chk($sformatf("R9 irq rise pin %0d", i), {30'h0, bank_irq}, {30'h0, stat_exp & be});
      wr(STAT, 32'hFFFF_FFFF);
      rchk($sformatf("R7 cleared pin %0d", i), STAT, 32'h0);
      @(negedge clk); ext[i] = 1'b0;
      settle();
      rchk($sformatf("R6 fall pin %0d", i), STAT, FMASK[i] ? (32'h1 << i) : 32'h0);
      stat_exp = FMASK[i] ? ((i < 16) ? 2'b01 : 2'b10) : 2'b00;
      chk($sformatf("R9 irq fall pin %0d", i), {30'h0, bank_irq}, {30'h0, stat_exp & be});
      wr(STAT, 32'hFFFF_FFFF);
    end

    wr(BE, 32'h3);
    @(negedge clk); ext = 32'h0001_0011;
    settle();
    rchk("R6 multi status", STAT, 32'h0001_0011);
    wr(STAT, 32'h0000_0000);
    rchk("R7 zero write keeps", STAT, 32'h0001_0011);
    wr(STAT, 32'h0000_0010);
    rchk("R7 partial clear", STAT, 32'h0001_0001);
    #1 chk("R9 both banks", {30'h0, bank_irq}, 32'h3);
    wr(STAT, 32'h0000_0001);
    #1 chk("R9 low bank drops", {30'h0, bank_irq}, 32'h2);
    wr(STAT, 32'hFFFF_FFFF);
    ext = '0;
    settle();
    wr(STAT, 32'hFFFF_FFFF);

    @(negedge clk); ext[5] = 1'b1;
    settle();
    @(negedge clk); ext[5] = 1'b0;
    settle();
    rchk("R8 precondition", STAT, 32'h20);
    @(negedge clk); ext[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(STAT, 32'h20);
    rchk("R8 edge wins over clear", STAT, 32'h20);
    wr(STAT, 32'h20);
    rchk("R7 plain clear", STAT, 32'h0);

    wr(RCLR, 32'h0000_00F0);
    wr(FCLR, 32'hFFFF_0000);
    rchk("R5 rise after clear", RSET, RMASK & ~32'h0000_00F0);
    rchk("R5 fall after clear", FSET, FMASK & 32'h0000_FFFF);
    @(negedge clk); ext[4] = 1'b1;
    settle();
    rchk("R6 disabled edge ignored", STAT, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule